// File: doc/BRIEF.md
# Passive LCD Frame Timing Generator

This block produces the line and frame timing for a single-scan passive color LCD. It counts pixel clocks within a line and lines within a frame. From these counts it drives a line strobe on every line, a frame strobe on the first visible line, and an AC-inversion (MOD) level that flips once per frame. It also gives the pixel data path two qualifiers: one says whether the current line is visible, and one says whether the current clock falls in the visible part of that line.

Horizontal sizes are set in groups of eight pixel clocks with a plus-one offset. Vertical sizes are set in lines. Software supplies a total and a visible size for each axis. The blank portion of each axis is the total minus the visible size, so it is never programmed on its own. Every frame opens with its blank lines and then shows its visible lines. The four size inputs are captured only at reset and at the frame boundary, so a frame that is running never mixes two settings.

Top module: `lcd_frame_timer`

## Requirements
- R1: A line lasts (ht_cfg+1)*8 pixel clocks. An ht_cfg value of 0 behaves as 1, so the shortest line is 16 clocks.
- R2: On a visible line, pix_en is high for the first (hd_cfg+1)*8 clocks of the line and low for the rest. If hd_cfg is not smaller than the effective ht_cfg, it is clamped to the effective ht_cfg minus 1.
- R3: line_pulse is high for exactly 8 clocks on every line, blank or visible. It starts on the clock right after the visible window of that line ends.
- R4: A frame has vt_cfg+1 lines. The first vt_cfg-vd_cfg lines are blank (line_disp low) and the other vd_cfg+1 lines are visible (line_disp high). If vd_cfg is greater than vt_cfg, it is clamped to vt_cfg, which leaves no blank lines.
- R5: frame_pulse is high only while line_pulse is high on the first visible line of a frame. It is low at all other times.
- R6: mod_out is 0 after reset and inverts exactly once per frame, on the clock where a new frame begins.
- R7: The size inputs take effect only at reset or at the start of the next frame. A change made in the middle of a frame leaves that frame's timing as it was.
- R8: While reset is high, the counters go to column 0 of line 0, which is the start of the blank lines. On the first clock after reset, line_pulse, frame_pulse and mod_out are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ht_cfg | input | 7 | Line total in units of 8 clocks, minus one |
| hd_cfg | input | 7 | Visible line width in units of 8 clocks, minus one |
| vt_cfg | input | 10 | Frame total in lines, minus one |
| vd_cfg | input | 10 | Visible lines, minus one |
| line_pulse | output | 1 | Line strobe, 8 clocks per line |
| frame_pulse | output | 1 | Frame strobe, during the line strobe of the first visible line |
| mod_out | output | 1 | AC inversion level, flips once per frame |
| line_disp | output | 1 | Current line is visible |
| pix_en | output | 1 | Current clock is in the visible window of a visible line |

## Verification
The bench changes the size inputs halfway through a frame. A design that applies the new values at once would stretch or cut short the line or frame that is running, and the per-clock model would disagree with it. The bench also sets a visible height above the total and a visible width at or above the total, and it sets a line total of zero. A design without the clamps would wrap its blank count or never raise its line strobe, and the comparisons on line_disp and line_pulse would catch it. Running back-to-back frames checks that MOD flips on each frame boundary and that the frame strobe lands only on the first visible line, including a frame with no blank lines where that line is line 0.

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int HW   = 7,
  parameter int VW   = 10,
  parameter int UNIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] ht_cfg,
  input  logic [HW-1:0] hd_cfg,
  input  logic [VW-1:0] vt_cfg,
  input  logic [VW-1:0] vd_cfg,
  output logic          line_pulse,
  output logic          frame_pulse,
  output logic          mod_out,
  output logic          line_disp,
  output logic          pix_en
);
  localparam int PW = (UNIT > 1) ? $clog2(UNIT) : 1;

  logic [PW-1:0] sub;
  logic [HW-1:0] col, ht_s, hd_s;
  logic [VW-1:0] row, vt_s, vd_s;
  logic          mod_q;

  wire [HW-1:0] ht_e = (ht_s == '0) ? HW'(1) : ht_s;
  wire [HW-1:0] hd_e = (hd_s >= ht_e) ? ht_e - HW'(1) : hd_s;
  wire [VW-1:0] vd_e = (vd_s > vt_s) ? vt_s : vd_s;
  wire [VW-1:0] blank_n = vt_s - vd_e;

  wire sub_last  = (sub == PW'(UNIT - 1));
  wire line_end  = sub_last && (col == ht_e);
  wire frame_end = line_end && (row == vt_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      sub   <= '0;
      col   <= '0;
      row   <= '0;
      mod_q <= 1'b0;
      ht_s  <= ht_cfg;
      hd_s  <= hd_cfg;
      vt_s  <= vt_cfg;
      vd_s  <= vd_cfg;
    end else begin
      sub <= sub_last ? '0 : sub + PW'(1);
      if (sub_last)
        col <= (col == ht_e) ? '0 : col + HW'(1);
      if (line_end)
        row <= (row == vt_s) ? '0 : row + VW'(1);
      if (frame_end) begin
        mod_q <= ~mod_q;
        ht_s  <= ht_cfg;
        hd_s  <= hd_cfg;
        vt_s  <= vt_cfg;
        vd_s  <= vd_cfg;
      end
    end
  end

  assign line_disp   = (row >= blank_n);
  assign pix_en      = line_disp && (col <= hd_e);
  assign line_pulse  = (col == hd_e + HW'(1));
  assign frame_pulse = line_pulse && (row == blank_n);
  assign mod_out     = mod_q;

  wire at_origin = (sub == '0) && (col == '0) && (row == '0);

  // R3: the strobe never overlaps the visible window
  a_r3_pulse_outside_window: assert property (@(posedge clk) disable iff (rst)
    line_pulse |-> !pix_en);
  // R3: the strobe starts on a unit boundary
  a_r3_pulse_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(line_pulse) |-> (sub == '0));
  // R5: the frame strobe only appears inside a line strobe
  a_r5_frame_in_line: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |-> line_pulse);
  // R6: MOD only changes when a new frame begins
  a_r6_mod_at_origin: assert property (@(posedge clk) disable iff (rst)
    !$stable(mod_out) |-> at_origin);
  // R7: captured sizes only change when a new frame begins
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable({ht_s, hd_s, vt_s, vd_s}) |-> at_origin);
  // R4: the row count never passes the frame total
  a_r4_row_bound: assert property (@(posedge clk) disable iff (rst)
    row <= vt_s);
endmodule

// File: tb/lcd_frame_timer_tb.sv
module lcd_frame_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] ht_cfg, hd_cfg;
  logic [9:0] vt_cfg, vd_cfg;
  logic       line_pulse, frame_pulse, mod_out, line_disp, pix_en;

  int checks = 0;
  int errors = 0;
  int m_ht, m_hd, m_vt, m_vd;
  bit exp_mod;

  always #2.5ns clk = ~clk;

  lcd_frame_timer u_dut (
    .clk(clk), .rst(rst),
    .ht_cfg(ht_cfg), .hd_cfg(hd_cfg), .vt_cfg(vt_cfg), .vd_cfg(vd_cfg),
    .line_pulse(line_pulse), .frame_pulse(frame_pulse), .mod_out(mod_out),
    .line_disp(line_disp), .pix_en(pix_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int ht, input int hd, input int vt, input int vd);
    ht_cfg = 7'(ht); hd_cfg = 7'(hd); vt_cfg = 10'(vt); vd_cfg = 10'(vd);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_ht = ht_cfg; m_hd = hd_cfg; m_vt = vt_cfg; m_vd = vd_cfg;
    exp_mod = 1'b0;
    chk("R8 line_pulse", line_pulse, 1'b0);
    chk("R8 frame_pulse", frame_pulse, 1'b0);
    chk("R8 mod_out", mod_out, 1'b0);
    chk("R8 line_disp", line_disp, (m_vd >= m_vt));
    chk("R8 pix_en", pix_en, (m_vd >= m_vt));
  endtask

  // Checks one full frame with the model's sizes; the next sizes are driven mid-frame (R7)
  task automatic run_frame(input int nht, input int nhd, input int nvt, input int nvd);
    int hte, hde, vde, blank, len, flen;
    hte   = (m_ht == 0) ? 1 : m_ht;
    hde   = (m_hd >= hte) ? hte - 1 : m_hd;
    vde   = (m_vd > m_vt) ? m_vt : m_vd;
    blank = m_vt - vde;
    len   = (hte + 1) * 8;
    flen  = len * (m_vt + 1);
    for (int t = 0; t < flen; t++) begin
      int ln, unit;
      bit disp, lp;
      ln   = t / len;
      unit = (t % len) / 8;
      disp = (ln >= blank);
      lp   = (unit == hde + 1);
      chk("R4 line_disp", line_disp, disp);
      chk("R1 R2 pix_en", pix_en, disp && (unit <= hde));
      chk("R1 R3 line_pulse", line_pulse, lp);
      chk("R5 frame_pulse", frame_pulse, lp && (ln == blank));
      chk("R6 mod_out", mod_out, exp_mod);
      if (t == flen / 2) set_cfg(nht, nhd, nvt, nvd);
      @(negedge clk);
    end
    m_ht = ht_cfg; m_hd = hd_cfg; m_vt = vt_cfg; m_vd = vd_cfg;
    exp_mod = ~exp_mod;
  endtask

  task automatic t_reset_and_basic();
    set_cfg(3, 1, 5, 3);
    do_reset();
    run_frame(3, 1, 5, 3);
    run_frame(3, 1, 5, 3);
  endtask

  task automatic t_midframe_change();
    run_frame(4, 2, 3, 1);  // R7: still old sizes this frame
    run_frame(2, 5, 2, 7);  // new sizes apply here
  endtask

  task automatic t_clamps();
    run_frame(0, 0, 1, 0);  // R2 R4 clamps: width to total-1, no blank lines
    run_frame(3, 1, 5, 3);  // R1: zero line total acts as one
    run_frame(3, 1, 5, 3);
  endtask

  task automatic t_reset_midframe();
    repeat (50) @(negedge clk);
    set_cfg(1, 0, 2, 1);
    do_reset();             // R8: reset from mid-frame restarts at line 0
    run_frame(1, 0, 2, 1);
  endtask

  initial begin
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_and_basic();
    t_midframe_change();
    t_clamps();
    t_reset_midframe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule